// File: doc/BRIEF.md
# I/O Processor Command Engine

This engine takes block transfers off the CPU. The CPU hands it a target device number and the memory address of a command record for that device, in a single start pulse. The engine then reads the four-word record from memory by itself, decodes it, and moves the requested number of words between the selected device port and a memory buffer. The CPU takes no part in the transfer.

Memory is shared with the CPU through a request/grant arbiter. The engine takes single bus cycles from the CPU. It releases the bus for one cycle after every word, so a CPU that is also requesting can win the next cycle. When the command finishes, or is rejected, the engine raises an interrupt. The interrupt and the error bit of the status stay set until the CPU clears them.

Top module: `iop_engine`

## Requirements
- R1: While reset is active and after it is released, `busy_o`, `irq_o`, `err_o`, `mem_req_o`, `dev_rx_ready_o` and `dev_tx_valid_o` are all low.
- R2: A `start_i` pulse is accepted only while the engine is idle and no interrupt is pending. The next cycle `busy_o` is high. A start seen while busy or while `irq_o` is high has no effect.
- R3: After a start, the engine issues memory reads at word addresses ptr, ptr+1, ptr+2 and ptr+3, in that order. These words give, in order: the opcode, the buffer address (low ADDR_W bits), the word count (low CNT_W bits, upper bits ignored) and the options (low OPT_W bits). The options are then shown on `opt_o`.
- R4: `mem_req_o` stays high, with `mem_addr_o` unchanged, until `mem_gnt_i` is seen. In the cycle after every granted word, `mem_req_o` is low.
- R5: A device word moves only in a cycle where valid and ready are both high. `dev_tx_valid_o` holds, with stable data, until accepted. The engine never drives `dev_tx_valid_o` and `dev_rx_ready_o` in the same cycle.
- R6: Opcode 1 (device to memory) takes count words from the receive port and writes them, in arrival order, to buffer, buffer+1, and so on.
- R7: Opcode 0 (memory to device) reads count words from buffer onward and presents them on the transmit port in address order.
- R8: A count of zero moves no data and raises `irq_o` with `err_o` low.
- R9: An opcode word other than 0 or 1 moves no data, sets `err_o` and raises `irq_o`. `err_o` is never high without `irq_o`.
- R10: `irq_o` and `err_o` stay high until an `irq_clr_i` pulse, which clears both the next cycle.
- R11: `dev_sel_o` shows the device number latched at the accepted start, and holds it for the whole command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse from the CPU |
| dev_id_i | input | DEV_W | Target device number |
| cmd_ptr_i | input | ADDR_W | Word address of the command record |
| irq_clr_i | input | 1 | CPU clear of interrupt and error |
| busy_o | output | 1 | Command in progress |
| irq_o | output | 1 | Completion interrupt, sticky |
| err_o | output | 1 | Status error bit: undefined opcode |
| opt_o | output | OPT_W | Option bits from the record |
| dev_sel_o | output | DEV_W | Selected device number |
| mem_req_o | output | 1 | Memory bus request |
| mem_gnt_i | input | 1 | Memory bus grant |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, valid in the grant cycle |
| dev_rx_valid_i | input | 1 | Device has a word for memory |
| dev_rx_ready_o | output | 1 | Engine accepts a device word |
| dev_rx_data_i | input | DATA_W | Word from the device |
| dev_tx_valid_o | output | 1 | Engine offers a word to the device |
| dev_tx_ready_i | input | 1 | Device accepts the word |
| dev_tx_data_o | output | DATA_W | Word to the device |

## Verification
The embedded properties check the bus rules on every cycle. They cover the held request and address until grant, the released cycle after each grant, the held transmit word, and the exclusive direction of the device port. They also cover the sticky interrupt, the error bit only under an interrupt, and the stable device select. What only the bench scenarios can show is the content of each transfer: the record read order, the data landing at the right buffer addresses in order, and the exact number of words moved. The same holds for zero counts, rejected opcodes and ignored starts. For these the bench keeps models of memory, device and a competing CPU, and compares them with values derived from each command.

// File: rtl/iop_pkg.sv
package iop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_DEV_RD,
    ST_MEM_WR,
    ST_MEM_RD,
    ST_DEV_WR
  } iop_state_e;

  localparam logic [1:0] REC_OP   = 2'd0;
  localparam logic [1:0] REC_BUF  = 2'd1;
  localparam logic [1:0] REC_CNT  = 2'd2;
  localparam logic [1:0] REC_OPT  = 2'd3;
endpackage

// File: rtl/iop_mem_port.sv
module iop_mem_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              want_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              mem_req_o,
  input  logic              mem_gnt_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              xfer_o
);
  logic gap_q;

  // one idle cycle after each granted word lets the CPU in
  assign mem_req_o   = want_i & ~gap_q;
  assign mem_we_o    = mem_req_o & we_i;
  assign mem_addr_o  = addr_i;
  assign mem_wdata_o = wdata_i;
  assign xfer_o      = mem_req_o & mem_gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gap_q <= 1'b0;
    else         gap_q <= xfer_o;
  end

  AST_GAP_AFTER_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_gnt_i |=> !mem_req_o); // R4
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o)); // R4
endmodule

// File: rtl/iop_dev_port.sv
module iop_dev_port #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              tx_en_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              rx_fire_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              tx_fire_o,
  input  logic              dev_rx_valid_i,
  output logic              dev_rx_ready_o,
  input  logic [DATA_W-1:0] dev_rx_data_i,
  output logic              dev_tx_valid_o,
  input  logic              dev_tx_ready_i,
  output logic [DATA_W-1:0] dev_tx_data_o
);
  assign dev_rx_ready_o = rx_en_i;
  assign rx_fire_o      = rx_en_i & dev_rx_valid_i;
  assign rx_data_o      = dev_rx_data_i;
  assign dev_tx_valid_o = tx_en_i;
  assign dev_tx_data_o  = tx_data_i;
  assign tx_fire_o      = tx_en_i & dev_tx_ready_i;

  AST_TX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_tx_valid_o && !dev_tx_ready_i |=> dev_tx_valid_o && $stable(dev_tx_data_o)); // R5
  AST_ONE_DIRECTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dev_tx_valid_o && dev_rx_ready_o)); // R5
endmodule

// File: rtl/iop_ctrl.sv
module iop_ctrl
  import iop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int OPT_W  = 8,
  parameter int DEV_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DEV_W-1:0]  dev_id_i,
  input  logic [ADDR_W-1:0] cmd_ptr_i,
  input  logic              irq_clr_i,
  input  logic              mem_xfer_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              rx_fire_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              tx_fire_i,
  output logic              mem_want_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic              err_o,
  output logic [DEV_W-1:0]  dev_sel_o,
  output logic [OPT_W-1:0]  opt_o
);
  iop_state_e        state_q;
  logic [DEV_W-1:0]  dev_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [1:0]        widx_q;
  logic [DATA_W-1:0] op_q;
  logic [ADDR_W-1:0] buf_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [OPT_W-1:0]  opt_q;
  logic [DATA_W-1:0] data_q;
  logic              irq_q;
  logic              err_q;
  logic              start_ok;
  logic              op_bad;
  logic              last_word;

  assign start_ok  = start_i && (state_q == ST_IDLE) && !irq_q;
  assign op_bad    = |op_q[DATA_W-1:1];
  assign last_word = (cnt_q == CNT_W'(1));

  always_comb begin
    mem_want_o  = (state_q == ST_FETCH) || (state_q == ST_MEM_WR) || (state_q == ST_MEM_RD);
    mem_we_o    = (state_q == ST_MEM_WR);
    mem_addr_o  = (state_q == ST_FETCH) ? ptr_q + ADDR_W'(widx_q) : buf_q;
    mem_wdata_o = data_q;
    rx_en_o     = (state_q == ST_DEV_RD);
    tx_en_o     = (state_q == ST_DEV_WR);
    tx_data_o   = data_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dev_q   <= '0;
      ptr_q   <= '0;
      widx_q  <= '0;
      op_q    <= '0;
      buf_q   <= '0;
      cnt_q   <= '0;
      opt_q   <= '0;
      data_q  <= '0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (irq_clr_i) begin
        irq_q <= 1'b0;
        err_q <= 1'b0;
      end
      unique case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            dev_q   <= dev_id_i;
            ptr_q   <= cmd_ptr_i;
            widx_q  <= '0;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_xfer_i) begin
            unique case (widx_q)
              REC_OP:  op_q  <= mem_rdata_i;
              REC_BUF: buf_q <= mem_rdata_i[ADDR_W-1:0];
              REC_CNT: cnt_q <= mem_rdata_i[CNT_W-1:0];
              REC_OPT: opt_q <= mem_rdata_i[OPT_W-1:0];
              default: ;
            endcase
            widx_q <= widx_q + 2'd1;
            if (widx_q == REC_OPT) state_q <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          if (op_bad) begin
            err_q   <= 1'b1;
            irq_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (cnt_q == '0) begin
            irq_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (op_q[0]) begin
            state_q <= ST_DEV_RD;
          end else begin
            state_q <= ST_MEM_RD;
          end
        end
        ST_DEV_RD: begin
          if (rx_fire_i) begin
            data_q  <= rx_data_i;
            state_q <= ST_MEM_WR;
          end
        end
        ST_MEM_WR: begin
          if (mem_xfer_i) begin
            buf_q <= buf_q + ADDR_W'(1);
            cnt_q <= cnt_q - CNT_W'(1);
            if (last_word) begin
              irq_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_DEV_RD;
            end
          end
        end
        ST_MEM_RD: begin
          if (mem_xfer_i) begin
            data_q  <= mem_rdata_i;
            state_q <= ST_DEV_WR;
          end
        end
        ST_DEV_WR: begin
          if (tx_fire_i) begin
            buf_q <= buf_q + ADDR_W'(1);
            cnt_q <= cnt_q - CNT_W'(1);
            if (last_word) begin
              irq_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_MEM_RD;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign irq_o     = irq_q;
  assign err_o     = err_q;
  assign dev_sel_o = dev_q;
  assign opt_o     = opt_q;

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr_i |=> irq_o); // R10
  AST_ERR_UNDER_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> irq_o); // R9
  AST_DEV_SEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(dev_sel_o)); // R11
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_want_o && !rx_en_o && !tx_en_o); // R1
endmodule

// File: rtl/iop_engine.sv
module iop_engine #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int OPT_W  = 8,
  parameter int DEV_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DEV_W-1:0]  dev_id_i,
  input  logic [ADDR_W-1:0] cmd_ptr_i,
  input  logic              irq_clr_i,
  output logic              busy_o,
  output logic              irq_o,
  output logic              err_o,
  output logic [OPT_W-1:0]  opt_o,
  output logic [DEV_W-1:0]  dev_sel_o,
  output logic              mem_req_o,
  input  logic              mem_gnt_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              dev_rx_valid_i,
  output logic              dev_rx_ready_o,
  input  logic [DATA_W-1:0] dev_rx_data_i,
  output logic              dev_tx_valid_o,
  input  logic              dev_tx_ready_i,
  output logic [DATA_W-1:0] dev_tx_data_o
);
  logic              want, we, xfer;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, tx_data, rx_data;
  logic              rx_en, tx_en, rx_fire, tx_fire;

  iop_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .OPT_W(OPT_W), .DEV_W(DEV_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .dev_id_i    (dev_id_i),
    .cmd_ptr_i   (cmd_ptr_i),
    .irq_clr_i   (irq_clr_i),
    .mem_xfer_i  (xfer),
    .mem_rdata_i (mem_rdata_i),
    .rx_fire_i   (rx_fire),
    .rx_data_i   (rx_data),
    .tx_fire_i   (tx_fire),
    .mem_want_o  (want),
    .mem_we_o    (we),
    .mem_addr_o  (addr),
    .mem_wdata_o (wdata),
    .rx_en_o     (rx_en),
    .tx_en_o     (tx_en),
    .tx_data_o   (tx_data),
    .busy_o      (busy_o),
    .irq_o       (irq_o),
    .err_o       (err_o),
    .dev_sel_o   (dev_sel_o),
    .opt_o       (opt_o)
  );

  iop_mem_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .want_i      (want),
    .we_i        (we),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .mem_req_o   (mem_req_o),
    .mem_gnt_i   (mem_gnt_i),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .xfer_o      (xfer)
  );

  iop_dev_port #(.DATA_W(DATA_W)) u_dev (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rx_en_i        (rx_en),
    .tx_en_i        (tx_en),
    .tx_data_i      (tx_data),
    .rx_fire_o      (rx_fire),
    .rx_data_o      (rx_data),
    .tx_fire_o      (tx_fire),
    .dev_rx_valid_i (dev_rx_valid_i),
    .dev_rx_ready_o (dev_rx_ready_o),
    .dev_rx_data_i  (dev_rx_data_i),
    .dev_tx_valid_o (dev_tx_valid_o),
    .dev_tx_ready_i (dev_tx_ready_i),
    .dev_tx_data_o  (dev_tx_data_o)
  );
endmodule

// File: tb/iop_engine_tb.sv
module iop_engine_tb;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int OPT_W  = 8;
  localparam int DEV_W  = 4;

  typedef struct packed {
    logic [31:0] op;
    logic [7:0]  ptr;
    logic [7:0]  bufa;
    logic [7:0]  cnt;
    logic [3:0]  dev;
    logic [7:0]  opt;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0001, 8'h10, 8'h40, 8'd5, 4'h3, 8'h5A},
    '{32'h0000_0000, 8'h14, 8'h60, 8'd4, 4'h7, 8'hA5},
    '{32'h0000_0001, 8'h18, 8'h80, 8'd1, 4'h1, 8'h01},
    '{32'h0000_0000, 8'h1C, 8'h90, 8'd0, 4'h2, 8'h3C},
    '{32'h0000_0002, 8'h20, 8'hA0, 8'd3, 4'h5, 8'h77},
    '{32'h8000_0001, 8'h24, 8'hB0, 8'd2, 4'h9, 8'hC3},
    '{32'h0000_0000, 8'h28, 8'hC0, 8'd7, 4'hF, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DEV_W-1:0] dev_id = '0;
  logic [ADDR_W-1:0] cmd_ptr = '0;
  logic irq_clr = 1'b0;
  logic busy, irq, err;
  logic [OPT_W-1:0] opt;
  logic [DEV_W-1:0] dev_sel;
  logic mem_req, mem_gnt, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic rx_valid, rx_ready, tx_valid, tx_ready;
  logic [DATA_W-1:0] rx_data, tx_data;

  always #10 clk = ~clk;

  iop_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dev_id_i(dev_id),
    .cmd_ptr_i(cmd_ptr), .irq_clr_i(irq_clr), .busy_o(busy), .irq_o(irq),
    .err_o(err), .opt_o(opt), .dev_sel_o(dev_sel), .mem_req_o(mem_req),
    .mem_gnt_i(mem_gnt), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .dev_rx_valid_i(rx_valid), .dev_rx_ready_o(rx_ready), .dev_rx_data_i(rx_data),
    .dev_tx_valid_o(tx_valid), .dev_tx_ready_i(tx_ready), .dev_tx_data_o(tx_data)
  );

  // memory, device and competing CPU models
  logic [31:0] mem [256];
  logic [15:0] lfsr = 16'hACE1;
  int rx_idx = 0, tx_cnt = 0, wr_cnt = 0, rd_cnt = 0, gap_viol = 0;
  logic [7:0]  rd_log [256];
  logic [31:0] tx_log [256];
  logic last_fire = 1'b0;
  logic cpu_hog;

  assign cpu_hog   = lfsr[3] & lfsr[0];
  assign mem_gnt   = mem_req & ~cpu_hog;
  assign mem_rdata = mem[mem_addr[7:0]];
  assign rx_valid  = lfsr[5] | lfsr[9];
  assign rx_data   = 32'hA500_0000 + rx_idx;
  assign tx_ready  = lfsr[7] | lfsr[2];

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_log[rd_cnt[7:0]] <= mem_addr[7:0];
        rd_cnt <= rd_cnt + 1;
      end
    end
    if (rx_valid && rx_ready) rx_idx <= rx_idx + 1;
    if (tx_valid && tx_ready) begin
      tx_log[tx_cnt[7:0]] <= tx_data;
      tx_cnt <= tx_cnt + 1;
    end
    last_fire <= mem_req && mem_gnt;
    if (last_fire && mem_req) gap_viol <= gap_viol + 1;
  end

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat_mem(input logic [7:0] a);
    return 32'hC3C3_0000 ^ {16'h0, a, ~a};
  endfunction

  task automatic start_cmd(input logic [3:0] d, input logic [7:0] p);
    @(negedge clk);
    start = 1'b1; dev_id = d; cmd_ptr = {8'h00, p};
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R1: reset state, during and after reset
    chk(!busy && !irq && !err, "R1 reset status", {29'b0, busy, irq, err}, 32'h0);
    chk(!mem_req && !rx_ready && !tx_valid, "R1 reset ports", {29'b0, mem_req, rx_ready, tx_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !mem_req && !irq, "R1 idle after reset", {30'b0, busy, mem_req}, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      vec_t t = VECS[v];
      bit   bad = (t.op > 32'd1);
      int   moved = (bad || t.cnt == 0) ? 0 : int'(t.cnt);
      int   s_rx, s_tx, s_wr, s_rd, errs;
      logic [31:0] fa, fe;
      mem[t.ptr]      = t.op;
      mem[t.ptr + 1]  = {16'h0, t.bufa, 8'h00} >> 8;
      mem[t.ptr + 2]  = {16'hBEEF, 8'h00, t.cnt};
      mem[t.ptr + 3]  = {24'h123456, t.opt};
      for (int i = 0; i < 8; i++)
        mem[t.bufa + i] = (t.op == 0) ? pat_mem(t.bufa + 8'(i)) : 32'h0;
      s_rx = rx_idx; s_tx = tx_cnt; s_wr = wr_cnt; s_rd = rd_cnt;
      start_cmd(t.dev, t.ptr);
      chk(busy, "R2 busy after start", {31'b0, busy}, 32'h1);
      chk(dev_sel == t.dev, "R11 device select", {28'b0, dev_sel}, {28'b0, t.dev});
      wait_irq();
      chk(irq && !busy, "R10 irq at completion", {30'b0, irq, busy}, 32'h2);
      chk(err == bad, bad ? "R9 error bit" : "R8 no error", {31'b0, err}, {31'b0, bad});
      errs = 0; fa = 0; fe = 0;
      for (int i = 0; i < 4; i++)
        if (rd_log[8'(s_rd + i)] != t.ptr + 8'(i)) begin
          if (errs == 0) begin fa = {24'b0, rd_log[8'(s_rd + i)]}; fe = {24'b0, t.ptr + 8'(i)}; end
          errs++;
        end
      chk(errs == 0, "R3 record read order", fa, fe);
      chk(opt == t.opt, "R3 options field", {24'b0, opt}, {24'b0, t.opt});
      chk(rd_cnt - s_rd == 4 + ((t.op == 0) ? moved : 0), "R3 R7 read count",
          32'(rd_cnt - s_rd), 32'(4 + ((t.op == 0) ? moved : 0)));
      if (t.op == 1) begin
        chk(wr_cnt - s_wr == moved && rx_idx - s_rx == moved, "R6 words moved",
            32'(wr_cnt - s_wr), 32'(moved));
        errs = 0;
        for (int i = 0; i < moved; i++)
          if (mem[t.bufa + i] != 32'hA500_0000 + s_rx + i) begin
            if (errs == 0) begin fa = mem[t.bufa + i]; fe = 32'hA500_0000 + s_rx + i; end
            errs++;
          end
        chk(errs == 0, "R6 buffer content", fa, fe);
      end else begin
        chk(tx_cnt - s_tx == moved && wr_cnt == s_wr && rx_idx == s_rx,
            bad ? "R9 nothing moved" : (moved == 0 ? "R8 nothing moved" : "R7 words moved"),
            32'(tx_cnt - s_tx), 32'(moved));
        errs = 0;
        for (int i = 0; i < moved; i++)
          if (tx_log[8'(s_tx + i)] != pat_mem(t.bufa + 8'(i))) begin
            if (errs == 0) begin fa = tx_log[8'(s_tx + i)]; fe = pat_mem(t.bufa + 8'(i)); end
            errs++;
          end
        chk(errs == 0, "R7 device data order", fa, fe);
      end
      repeat (4) @(negedge clk);
      chk(irq && err == bad, "R10 irq and error held", {30'b0, irq, err}, {30'b0, 1'b1, bad});
      // R2: start while interrupt pending is ignored
      start_cmd(4'h8, 8'h10);
      chk(!busy && dev_sel == t.dev, "R2 start ignored while irq pending",
          {27'b0, busy, dev_sel}, {28'b0, t.dev});
      clear_irq();
      chk(!irq && !err, "R10 clear", {30'b0, irq, err}, 32'h0);
    end

    // R2: start during a running command is ignored
    begin
      int s_rx, s_wr, s_rd;
      mem[8'h30] = 32'h1; mem[8'h31] = 32'hD0; mem[8'h32] = 32'h6; mem[8'h33] = 32'h0;
      s_rx = rx_idx; s_wr = wr_cnt; s_rd = rd_cnt;
      start_cmd(4'h6, 8'h30);
      repeat (8) @(negedge clk);
      start = 1'b1; dev_id = 4'h9; cmd_ptr = 16'h0014;
      @(negedge clk); start = 1'b0;
      chk(dev_sel == 4'h6, "R2 R11 select unchanged by busy start", {28'b0, dev_sel}, 32'h6);
      wait_irq();
      chk(wr_cnt - s_wr == 6 && rx_idx - s_rx == 6 && rd_cnt - s_rd == 4,
          "R2 only first command ran", 32'(wr_cnt - s_wr), 32'd6);
      clear_irq();
      repeat (3) @(negedge clk);
      chk(!busy && !irq, "R2 no delayed start", {30'b0, busy, irq}, 32'h0);
    end

    chk(gap_viol == 0, "R4 released cycle after each grant", 32'(gap_viol), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule